// File: doc/BRIEF.md
# Jam-Loaded Dual Down-Counter Divider

This block divides two source clocks for a phase comparator. A 15-bit reference counter steps on each rising edge of the oscillator source. A 16-bit feedback counter steps on each edge of the divided-down VCO source. Each counter counts down from its programmed ratio. At terminal count it reloads on the same source edge, so its output period is exactly the ratio in source edges. The reference output is a positive pulse lasting four and a half oscillator cycles. The feedback output is a positive pulse lasting one feedback source cycle.

A jam strobe restarts both counters together from their programmed ratios and clears both output pulses. The two divided outputs then start from a common, known phase, which matters whenever a new feedback ratio is written. A reference ratio of 0 or 1 bypasses the counter and passes the oscillator level straight to the reference output. Feedback ratios below 40 are raised to 40.

Both sources are modelled inside one system clock domain. The oscillator is presented as a level plus a rising-edge enable and a falling-edge enable. The feedback source is presented as one edge enable.

Top module: `jam_divider_pair`

## Requirements
- R1: In any cycle with `rst_n` low, both outputs are low at the next edge, and both counters load their effective ratios, exactly as a jam would. With `ref_ratio` of 2 or more, the first reference terminal count therefore falls on the `ref_ratio`-th rising enable after reset.
- R2: With `ref_ratio` of 2 or more, the reference counter reaches terminal count on every `ref_ratio`-th cycle with `ref_rise` high, counted from the last jam or reset. Each such cycle reloads the counter.
- R3: Outside bypass, `ref_pulse` goes high at the edge that ends a reference terminal cycle. It goes low at the edge that ends the fifth following cycle with `ref_fall` high, which makes a width of 4.5 oscillator cycles. A new terminal count while the pulse is high restarts this width.
- R4: When `ref_ratio` is 0 or 1, `ref_pulse` equals `ref_osc` combinationally.
- R5: The feedback counter reaches terminal count on every N-th cycle with `fb_tick` high, counted from the last jam or reset, where N is the effective feedback ratio. Each such cycle reloads the counter.
- R6: `fb_pulse` goes high at the edge that ends a feedback terminal cycle and goes low at the edge that ends the next cycle with `fb_tick` high.
- R7: A `fb_ratio` below 40, including 0, acts as a ratio of 40.
- R8: A cycle with `jam` high reloads both counters and clears both pulse outputs. A `ref_rise`, `ref_fall` or `fb_tick` in that same cycle has no effect.
- R9: In a cycle without its source enable and without jam, a counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_osc | input | 1 | Oscillator level, used in bypass |
| ref_rise | input | 1 | One-cycle enable marking an oscillator rising edge |
| ref_fall | input | 1 | One-cycle enable marking an oscillator falling edge |
| fb_tick | input | 1 | One-cycle enable marking a feedback source edge |
| jam | input | 1 | Restart strobe for both counters |
| ref_ratio | input | 15 | Reference divide ratio |
| fb_ratio | input | 16 | Feedback divide ratio |
| ref_pulse | output | 1 | Reference-divided output |
| fb_pulse | output | 1 | Feedback-divided output |

## Verification
The bench sweeps reference ratios from 0 up through small values, including 2 and 3, where the 4.5-cycle pulse is longer than the period. A design that let the pulse lapse before restarting it would show gaps there. It also sweeps feedback ratios below, at and just above the floor of 40. A design without the clamp would produce short periods for those values, and an off-by-one reload would show up as a period of N+1. Every configuration begins with a jam that carries concurrent source edges and lands in the middle of the previous configuration's pulses. A design that let those edges count, or that left a stale pulse high, would be shifted by one source edge from the expected waveform or would show a stray high output.

// File: rtl/jdiv_pkg.sv
`timescale 1ns/1ps
// Shared constants for the jam-loaded divider pair.
// Assumes: ratios are unsigned binary; the reference pulse width is given in
// half oscillator cycles so that a fractional width can be expressed.
package jdiv_pkg;
    localparam int unsigned REF_BITS     = 15;  // reference counter stages
    localparam int unsigned FB_BITS      = 16;  // feedback counter stages
    localparam int unsigned FB_FLOOR     = 40;  // smallest usable feedback ratio
    localparam int unsigned REF_HALVES   = 9;   // reference pulse width in half cycles
endpackage

// File: rtl/jdiv_down_counter.sv
`timescale 1ns/1ps
// Programmable down-counter with same-edge reload.
// Counts source edges (tick) from the effective ratio down to 1; the tick that
// finds the count at 1 is the terminal one and reloads the ratio, so the period
// is exactly the effective ratio. Ratios below MIN_RATIO act as MIN_RATIO.
// Assumes: jam and reset have priority over tick; all inputs are synchronous.
module jdiv_down_counter #(
    parameter int unsigned W         = 16,
    parameter int unsigned MIN_RATIO = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         jam,
    input  logic [W-1:0] ratio,
    output logic [W-1:0] count_o,
    output logic         tc_o
);
    localparam logic [W-1:0] MIN_V = W'(MIN_RATIO);
    localparam logic [W-1:0] ONE_V = W'(1);

    logic [W-1:0] eff_ratio;
    logic [W-1:0] cnt_q;

    // Clamp the programmed ratio to the usable minimum.
    assign eff_ratio = (ratio < MIN_V) ? MIN_V : ratio;

    // Terminal count: a live tick that finds the counter at its last state.
    assign tc_o    = tick && !jam && (cnt_q <= ONE_V);
    assign count_o = cnt_q;

    // Load on reset or jam, reload at terminal count, otherwise decrement per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || jam) begin
            cnt_q <= eff_ratio;
        end else if (tick) begin
            if (cnt_q <= ONE_V) begin
                cnt_q <= eff_ratio;
            end else begin
                cnt_q <= cnt_q - ONE_V;
            end
        end
    end
endmodule

// File: rtl/jdiv_half_stretch.sv
`timescale 1ns/1ps
// Pulse stretcher timed in half source cycles.
// A start (on a rising-edge cycle) raises the output; it falls after the
// (HALVES+1)/2-th falling-edge enable that follows. With HALVES odd this gives
// a width of HALVES/2 source cycles. A new start restarts the width.
// Assumes: start and fall_en never coincide (they mark opposite source edges).
module jdiv_half_stretch #(
    parameter int unsigned HALVES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic jam,
    input  logic start,
    input  logic fall_en,
    output logic pulse_o
);
    localparam int unsigned FALLS = (HALVES + 1) / 2;
    localparam int unsigned CW    = (FALLS > 1) ? $clog2(FALLS) : 1;
    localparam logic [CW-1:0] LAST = CW'(FALLS - 1);

    logic          act_q;
    logic [CW-1:0] fall_q;

    // Track the pulse and count falling edges seen since it started.
    always_ff @(posedge clk) begin
        if (!rst_n || jam) begin
            act_q  <= 1'b0;
            fall_q <= '0;
        end else if (start) begin
            act_q  <= 1'b1;
            fall_q <= '0;
        end else if (act_q && fall_en) begin
            if (fall_q == LAST) begin
                act_q  <= 1'b0;
                fall_q <= '0;
            end else begin
                fall_q <= fall_q + CW'(1);
            end
        end
    end

    assign pulse_o = act_q;
endmodule

// File: rtl/jam_divider_pair.sv
`timescale 1ns/1ps
// Dual jam-loaded divider: reference and feedback down-counters that restart
// together on a jam strobe and drive the two inputs of a phase comparator.
// Reference output: 4.5-cycle high pulse per period, or the oscillator level
// itself when the reference ratio is 0 or 1. Feedback output: one feedback
// source cycle high per period.
// Assumes: both sources are presented as edge enables in the clk domain.
module jam_divider_pair
    import jdiv_pkg::*;
#(
    parameter int unsigned RW      = REF_BITS,
    parameter int unsigned FW      = FB_BITS,
    parameter int unsigned FB_MIN  = FB_FLOOR,
    parameter int unsigned HALVES  = REF_HALVES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_osc,
    input  logic          ref_rise,
    input  logic          ref_fall,
    input  logic          fb_tick,
    input  logic          jam,
    input  logic [RW-1:0] ref_ratio,
    input  logic [FW-1:0] fb_ratio,
    output logic          ref_pulse,
    output logic          fb_pulse
);
    logic [RW-1:0] ref_cnt;
    logic [FW-1:0] fb_cnt;
    logic          ref_tc;
    logic          fb_tc;
    logic          ref_shaped;
    logic          ref_bypass;
    logic          fb_pulse_q;

    // Reference divider: ratio 0 behaves as 1.
    jdiv_down_counter #(.W(RW), .MIN_RATIO(1)) u_ref_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (ref_rise),
        .jam     (jam),
        .ratio   (ref_ratio),
        .count_o (ref_cnt),
        .tc_o    (ref_tc)
    );

    // Feedback divider: ratios below the floor behave as the floor.
    jdiv_down_counter #(.W(FW), .MIN_RATIO(FB_MIN)) u_fb_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (fb_tick),
        .jam     (jam),
        .ratio   (fb_ratio),
        .count_o (fb_cnt),
        .tc_o    (fb_tc)
    );

    // Reference pulse shaping in half oscillator cycles.
    jdiv_half_stretch #(.HALVES(HALVES)) u_ref_shape (
        .clk     (clk),
        .rst_n   (rst_n),
        .jam     (jam),
        .start   (ref_tc),
        .fall_en (ref_fall),
        .pulse_o (ref_shaped)
    );

    // Feedback pulse: set by a terminal tick, cleared by the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n || jam) begin
            fb_pulse_q <= 1'b0;
        end else if (fb_tick) begin
            fb_pulse_q <= fb_tc;
        end
    end

    // Divide-by-one bypass selects the raw oscillator level.
    assign ref_bypass = (ref_ratio <= RW'(1));
    assign ref_pulse  = ref_bypass ? ref_osc : ref_shaped;
    assign fb_pulse   = fb_pulse_q;
endmodule

// File: rtl/jdiv_checker.sv
`timescale 1ns/1ps
// Property checker for jam_divider_pair, attached by bind.
// Assumes: ratios are held steady except around a jam, as in normal use.
module jdiv_checker #(
    parameter int unsigned RW     = 15,
    parameter int unsigned FW     = 16,
    parameter int unsigned FB_MIN = 40
) (
    input logic          clk,
    input logic          rst_n,
    input logic          jam,
    input logic          ref_rise,
    input logic          fb_tick,
    input logic [RW-1:0] ref_ratio,
    input logic [FW-1:0] fb_ratio,
    input logic [RW-1:0] ref_cnt,
    input logic [FW-1:0] fb_cnt,
    input logic          ref_pulse,
    input logic          fb_pulse
);
    AST_RESET_FB_LOW: assert property (@(posedge clk)
        !rst_n |=> !fb_pulse);  // R1

    AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!jam && ref_rise && ref_cnt > RW'(1)) |=> (ref_cnt == $past(ref_cnt) - RW'(1)));  // R2

    AST_REF_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!jam && ref_rise && ref_cnt == RW'(1) && ref_ratio > RW'(1) && $stable(ref_ratio))
        |=> ref_pulse);  // R3

    AST_FB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!jam && fb_tick && fb_cnt > FW'(1)) |=> (fb_cnt == $past(fb_cnt) - FW'(1)));  // R5

    AST_FB_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fb_cnt != '0);  // R5

    AST_FB_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_pulse && fb_tick) |=> !fb_pulse);  // R6

    AST_FB_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (jam && fb_ratio < FW'(FB_MIN)) |=> (fb_cnt == FW'(FB_MIN)));  // R7

    AST_JAM_LOADS_FB: assert property (@(posedge clk) disable iff (!rst_n)
        (jam && fb_ratio >= FW'(FB_MIN)) |=> (fb_cnt == $past(fb_ratio)));  // R8

    AST_JAM_LOADS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (jam && ref_ratio >= RW'(1)) |=> (ref_cnt == $past(ref_ratio)));  // R8

    AST_JAM_FB_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        jam |=> !fb_pulse);  // R8

    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!jam && !ref_rise) |=> $stable(ref_cnt));  // R9

    AST_FB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!jam && !fb_tick) |=> $stable(fb_cnt));  // R9
endmodule

bind jam_divider_pair jdiv_checker #(.RW(RW), .FW(FW), .FB_MIN(FB_MIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .jam       (jam),
    .ref_rise  (ref_rise),
    .fb_tick   (fb_tick),
    .ref_ratio (ref_ratio),
    .fb_ratio  (fb_ratio),
    .ref_cnt   (ref_cnt),
    .fb_cnt    (fb_cnt),
    .ref_pulse (ref_pulse),
    .fb_pulse  (fb_pulse)
);

// File: tb/jam_divider_pair_tb.sv
`timescale 1ns/1ps
// Bench: sweeps ratio pairs; oscillator period 4 clk (high 2, low 2, rise
// enable at phase 0, fall enable at phase 2); feedback tick every 2nd clk.
// Expected waveforms are computed arithmetically from the requirements.
module jam_divider_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_osc = 1'b0;
    logic        ref_rise = 1'b0;
    logic        ref_fall = 1'b0;
    logic        fb_tick = 1'b0;
    logic        jam = 1'b0;
    logic [14:0] ref_ratio = 15'd5;
    logic [15:0] fb_ratio = 16'd40;
    logic        ref_pulse;
    logic        fb_pulse;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    jam_divider_pair u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_osc   (ref_osc),
        .ref_rise  (ref_rise),
        .ref_fall  (ref_fall),
        .fb_tick   (fb_tick),
        .jam       (jam),
        .ref_ratio (ref_ratio),
        .fb_ratio  (fb_ratio),
        .ref_pulse (ref_pulse),
        .fb_pulse  (fb_pulse)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run is a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input logic got, input logic exp, input string req, input int i);
        total = total + 1;
        if (got !== exp) begin
            bad = bad + 1;
            $display("FAIL %s at step %0d: actual=%b expected=%b", req, i, got, exp);
        end
    endtask

    // Reference: terminal on rise k = m*R (R2), at step t = 4*(m*R-1);
    // high for steps t..t+17, i.e. 4.5 osc cycles, restarted by overlap (R3).
    // Ratio 0/1: follows the oscillator level (R4).
    function automatic logic exp_ref(input int i, input int r);
        int eff = (r < 1) ? 1 : r;
        if (eff == 1) return ((i % 4) < 2);
        for (int m = 1; 4 * (m * eff - 1) <= i; m++) begin
            if (i <= 4 * (m * eff - 1) + 17) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Feedback: terminal on tick k = m*N (R5, N clamped to 40 per R7),
    // at step t = 2*(m*N-1); high for steps t and t+1 (R6).
    function automatic logic exp_fb(input int i, input int n);
        int eff = (n < 40) ? 40 : n;
        for (int m = 1; 2 * (m * eff - 1) <= i; m++) begin
            if (i <= 2 * (m * eff - 1) + 1) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Free-running source pattern after a jam or reset; counters must hold on
    // cycles without their enable for the periods to come out right (R9).
    task automatic run_loop(input int r, input int n, input int len, input string tag);
        for (int i = 0; i < len; i++) begin
            ref_osc  = ((i % 4) < 2);
            ref_rise = ((i % 4) == 0);
            ref_fall = ((i % 4) == 2);
            fb_tick  = ((i % 2) == 0);
            @(posedge clk);
            #1;
            check(ref_pulse, exp_ref(i, r),
                  $sformatf("%s ref r=%0d %s", tag, r, (r <= 1) ? "R4" : "R2 R3"), i);
            check(fb_pulse, exp_fb(i, n),
                  $sformatf("%s fb n=%0d %s", tag, n, (n < 40) ? "R7" : "R5 R6"), i);
        end
    endtask

    // Jam with source edges in the same cycle: they must not count (R8).
    task automatic run_cfg(input int r, input int n);
        ref_ratio = 15'(r);
        fb_ratio  = 16'(n);
        jam       = 1'b1;
        ref_osc   = 1'b0;
        ref_rise  = 1'b1;
        ref_fall  = 1'b0;
        fb_tick   = 1'b1;
        @(posedge clk);
        #1;
        jam = 1'b0;
        check(fb_pulse, 1'b0, "R8 jam clears fb", -1);
        run_loop(r, n, 420, "R8");
    endtask

    initial begin
        // Reset state (R1).
        repeat (3) @(posedge clk);
        #1;
        check(ref_pulse, 1'b0, "R1 reset ref", -1);
        check(fb_pulse, 1'b0, "R1 reset fb", -1);
        rst_n = 1'b1;
        run_loop(5, 40, 220, "R1");
        // Sweep, each start cutting into the previous pulses.
        run_cfg(0, 0);
        run_cfg(1, 39);
        run_cfg(2, 40);
        run_cfg(3, 41);
        run_cfg(5, 45);
        run_cfg(7, 40);
        run_cfg(12, 100);
        run_cfg(9, 2);
        run_cfg(6, 57);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule